// File: doc/BRIEF.md
# Decimating Integrator Sample Capture Controller

This block sits behind a multi-channel charge digitizer. Raw 16-bit words arrive one per `sampleValid` pulse, interleaved by channel in a fixed rotation. Each word is the charge collected over one short integration slot. For every channel, the block adds four consecutive words in a wide accumulator. It divides the total by four and writes the 16-bit average into an output FIFO, which a bus-side reader drains.

Capture is organised in acquisition cycles. A start pulse opens a cycle. The cycle closes on its own once a fixed number of averages has been produced for every channel: 500 per channel by default, which is 40 ms of data at an 80 µs result period. A done flag then stays up until the next start.

A single control register sets where the samples come from. The source is either live converter data or a deterministic on-chip test pattern that replaces the converter words. The test pattern lets the whole averaging and FIFO path be checked against values computed in advance. A write to the same register also clears the sticky flag that records results lost to a full FIFO.

Top module: `decim_capture`

## Requirements
- R1: After reset, fifoEmpty is 1 and fifoFull, cycleActive, cycleDone, overflow and testMode are all 0.
- R2: A cycleStart pulse while no cycle is running makes cycleActive 1 and cycleDone 0 from the next clock. The same pulse zeroes the channel rotation, the group position, the result count, every accumulator and the test-pattern address. Sample words presented while no cycle runs are ignored and produce no FIFO entry.
- R3: During a cycle, accepted words belong to channels 0, 1, ... NUM_CH-1 in rotation. Each channel adds four of its own consecutive words in an 18-bit accumulator. The sum is shifted right by two with truncation. The result is written to the FIFO on the clock of the fourth word, and it is readable on rdData after that clock. The accumulator restarts from zero.
- R4: After NUM_CH×RESULTS results (default 1000), cycleActive drops and cycleDone rises. cycleActive and cycleDone are never 1 together. Words arriving after that are ignored.
- R5: A cycleStart pulse while a cycle is running has no effect. The rotation, the accumulators and the result count carry on.
- R6: A result produced while the FIFO holds FIFO_DEPTH (16) entries is discarded, even if a read occurs on the same clock, and overflow becomes 1. overflow stays 1 until it is cleared.
- R7: Any write to address 0x01034 clears overflow, unless a result is discarded on the same clock, in which case overflow stays 1. Writes to other addresses change nothing.
- R8: Writing 0xFF00 to address 0x01034 sets testMode to 1 from the next clock. Writing any other value to that address sets it to 0.
- R9: While testMode is 1, sampleData is ignored. Each accepted word is instead test entry k = (0x0F0F + 0x1111·k) mod 2^16, for k from 0 to 7. k advances by one per accepted word, wraps from 7 to 0, and restarts at 0 on every cycle start.
- R10: The FIFO returns results in the order they were written. rdData always shows the oldest entry. rdEn pops one entry and is ignored when fifoEmpty is 1. fifoFull and fifoEmpty are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One raw word present this clock |
| sampleData | input | 16 | Raw converter word |
| cycleStart | input | 1 | Acquisition cycle start pulse |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 20 | Register write address |
| regWrData | input | 16 | Register write data |
| rdEn | input | 1 | Pop the oldest FIFO entry |
| rdData | output | 16 | Oldest FIFO entry |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |
| cycleActive | output | 1 | Acquisition cycle running |
| cycleDone | output | 1 | Last cycle completed |
| overflow | output | 1 | Sticky: a result was discarded |
| testMode | output | 1 | Test pattern replaces converter data |

## Verification
Two collisions matter most, and each has its own priority rule. In the first, a result is discarded by a full FIFO on the same clock as a clearing control write. The bench stops reading until the FIFO fills, then issues the write on the fourth word of a group. It expects overflow to stay 1, and to drop only after a later write that comes on its own. In the second, a result is pushed on the same clock as a read. This happens on every group during normal draining, and also while the FIFO is full. A cycle-accurate model of occupancy and expected contents judges both: it compares fifoFull, fifoEmpty and every popped word against sums computed from the stimulus.

// File: rtl/decim_capture_pkg.sv
`timescale 1ns/1ps
package decim_capture_pkg;

  // strobes passed from sequencing control to the datapath
  typedef struct packed {
    logic accept;     // a sample word is taken this clock
    logic lastPhase;  // the word completes its channel's group
    logic clearAcc;   // zero every accumulator
    logic useRom;     // take the test pattern instead of live data
  } capStrobe_t;

  // test pattern entry k
  function automatic logic [15:0] romPattern(input logic [15:0] idx);
    return 16'h0F0F + 16'h1111 * idx;
  endfunction

endpackage

// File: rtl/decim_capture_fifo.sv
`timescale 1ns/1ps
module decim_capture_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdReq,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      fill;
  logic             doPush, doPop;

  assign empty  = (fill == '0);
  assign full   = (fill == (AW+1)'(DEPTH));
  assign doPush = wrReq && !full;
  assign doPop  = rdReq && !empty;
  assign drop   = wrReq && full;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/decim_capture_ctrl.sv
`timescale 1ns/1ps
module decim_capture_ctrl
  import decim_capture_pkg::*;
#(
  parameter int              NUM_CH    = 2,
  parameter int              RESULTS   = 500,
  parameter int              GROUP     = 4,
  parameter int              ROM_DEPTH = 8,
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h01034,
  parameter logic [DATA_W-1:0] TEST_CODE = 16'hFF00,
  parameter int              CH_W      = 1,
  parameter int              RA_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              cycleStart,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              dropPulse,
  output capStrobe_t        strb,
  output logic [CH_W-1:0]   chIdx,
  output logic [RA_W-1:0]   romAddr,
  output logic              cycleActive,
  output logic              cycleDone,
  output logic              overflow,
  output logic              testMode
);
  localparam int PH_W  = $clog2(GROUP);
  localparam int TOTAL = NUM_CH * RESULTS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] resultCount;
  logic accept, lastPhase, lastCh, startNow, ctrlHit;

  assign accept    = cycleActive && sampleValid;
  assign lastPhase = (phase == PH_W'(GROUP-1));
  assign lastCh    = (chIdx == CH_W'(NUM_CH-1));
  assign startNow  = cycleStart && !cycleActive;
  assign ctrlHit   = regWrEn && (regWrAddr == CTRL_ADDR);

  assign strb.accept    = accept;
  assign strb.lastPhase = lastPhase;
  assign strb.clearAcc  = startNow;
  assign strb.useRom    = testMode;

  // sequencing: channel rotation, group position, result count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleActive <= 1'b0;
      cycleDone   <= 1'b0;
      chIdx       <= '0;
      phase       <= '0;
      resultCount <= '0;
      romAddr     <= '0;
    end else if (startNow) begin
      cycleActive <= 1'b1;
      cycleDone   <= 1'b0;
      chIdx       <= '0;
      phase       <= '0;
      resultCount <= '0;
      romAddr     <= '0;
    end else if (accept) begin
      romAddr <= (romAddr == RA_W'(ROM_DEPTH-1)) ? '0 : romAddr + 1'b1;
      chIdx   <= lastCh ? '0 : chIdx + 1'b1;
      if (lastCh) phase <= lastPhase ? '0 : phase + 1'b1;
      if (lastPhase) begin
        resultCount <= resultCount + 1'b1;
        if (resultCount == CNT_W'(TOTAL-1)) begin
          cycleActive <= 1'b0;
          cycleDone   <= 1'b1;
        end
      end
    end
  end

  // control register: source select and sticky loss flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflow <= 1'b0;
      testMode <= 1'b0;
    end else begin
      if (dropPulse)    overflow <= 1'b1;
      else if (ctrlHit) overflow <= 1'b0;
      if (ctrlHit) testMode <= (regWrData == TEST_CODE);
    end
  end
endmodule

// File: rtl/decim_capture_dpath.sv
`timescale 1ns/1ps
module decim_capture_dpath
  import decim_capture_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DATA_W     = 16,
  parameter int GROUP      = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int CH_W       = 1,
  parameter int RA_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strb,
  input  logic [CH_W-1:0]   chIdx,
  input  logic [RA_W-1:0]   romAddr,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              dropPulse
);
  localparam int SHIFT = $clog2(GROUP);
  localparam int ACC_W = DATA_W + SHIFT;

  logic [DATA_W-1:0] sampleWord, avgWord;
  logic [ACC_W-1:0]  acc [NUM_CH];
  logic [ACC_W-1:0]  selAcc, sumNext;
  logic              pushReq;

  // source mux: live words or test pattern
  assign sampleWord = strb.useRom ? DATA_W'(romPattern(16'(romAddr))) : sampleData;
  assign selAcc     = acc[chIdx];
  assign sumNext    = selAcc + ACC_W'(sampleWord);
  assign avgWord    = sumNext[ACC_W-1:SHIFT];
  assign pushReq    = strb.accept && strb.lastPhase;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAcc) begin
        acc[g] <= '0;
      end else if (strb.accept && (chIdx == CH_W'(g))) begin
        acc[g] <= strb.lastPhase ? '0 : sumNext;
      end
    end
  end

  decim_capture_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrReq  (pushReq),
    .wrData (avgWord),
    .rdReq  (rdEn),
    .rdData (rdData),
    .empty  (fifoEmpty),
    .full   (fifoFull),
    .drop   (dropPulse)
  );
endmodule

// File: rtl/decim_capture.sv
`timescale 1ns/1ps
module decim_capture
  import decim_capture_pkg::*;
#(
  parameter int                NUM_CH     = 2,
  parameter int                RESULTS    = 500,
  parameter int                GROUP      = 4,
  parameter int                ROM_DEPTH  = 8,
  parameter int                FIFO_DEPTH = 16,
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 20'h01034,
  parameter logic [DATA_W-1:0] TEST_CODE  = 16'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              cycleStart,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              cycleActive,
  output logic              cycleDone,
  output logic              overflow,
  output logic              testMode
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int RA_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  capStrobe_t      strb;
  logic [CH_W-1:0] chIdx;
  logic [RA_W-1:0] romAddr;
  logic            dropPulse;

  decim_capture_ctrl #(
    .NUM_CH(NUM_CH), .RESULTS(RESULTS), .GROUP(GROUP), .ROM_DEPTH(ROM_DEPTH),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .TEST_CODE(TEST_CODE),
    .CH_W(CH_W), .RA_W(RA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .cycleStart(cycleStart),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .dropPulse(dropPulse), .strb(strb), .chIdx(chIdx), .romAddr(romAddr),
    .cycleActive(cycleActive), .cycleDone(cycleDone), .overflow(overflow),
    .testMode(testMode)
  );

  decim_capture_dpath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .GROUP(GROUP), .FIFO_DEPTH(FIFO_DEPTH),
    .CH_W(CH_W), .RA_W(RA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .chIdx(chIdx), .romAddr(romAddr),
    .sampleData(sampleData), .rdEn(rdEn), .rdData(rdData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .dropPulse(dropPulse)
  );
endmodule

// File: rtl/decim_capture_chk.sv
`timescale 1ns/1ps
module decim_capture_chk #(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                CH_W      = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h01034,
  parameter logic [DATA_W-1:0] TEST_CODE = 16'hFF00
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              cycleStart,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              rdEn,
  input logic              fifoEmpty,
  input logic              fifoFull,
  input logic              cycleActive,
  input logic              cycleDone,
  input logic              overflow,
  input logic              testMode,
  input logic              dropPulse,
  input logic [CH_W-1:0]   chIdx
);
  logic ctrlHit;
  assign ctrlHit = regWrEn && (regWrAddr == CTRL_ADDR);

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !cycleActive) |=> (cycleActive && !cycleDone));

  p_idle_no_push_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleActive && !cycleStart && !rdEn && fifoEmpty) |=> fifoEmpty);

  p_active_done_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleActive && cycleDone));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && cycleActive && !sampleValid) |=> (cycleActive && $stable(chIdx)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |=> overflow);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ctrlHit) |=> overflow);

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && !dropPulse) |=> !overflow);

  p_mode_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> (testMode == ($past(regWrData) == TEST_CODE)));

  p_full_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));
endmodule

bind decim_capture decim_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
  .CTRL_ADDR(CTRL_ADDR), .TEST_CODE(TEST_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .cycleStart(cycleStart),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData), .rdEn(rdEn),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .cycleActive(cycleActive),
  .cycleDone(cycleDone), .overflow(overflow), .testMode(testMode),
  .dropPulse(dropPulse), .chIdx(chIdx)
);

// File: tb/tb_decim_capture.sv
`timescale 1ns/1ps
module tb_decim_capture;
  localparam int NUM_CH  = 2;
  localparam int RESULTS = 500;
  localparam int FDEPTH  = 16;
  localparam int ROMD    = 8;
  localparam logic [19:0] CTRL = 20'h01034;

  logic clk = 1'b0;
  logic rstN, sampleValid, cycleStart, regWrEn, rdEn;
  logic [15:0] sampleData, regWrData, rdData;
  logic [19:0] regWrAddr;
  logic fifoEmpty, fifoFull, cycleActive, cycleDone, overflow, testMode;

  always #2 clk = ~clk;

  decim_capture dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cycleStart(cycleStart), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .rdEn(rdEn), .rdData(rdData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .cycleActive(cycleActive), .cycleDone(cycleDone),
    .overflow(overflow), .testMode(testMode)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  int   mCount = 0;
  int   expQ[$];
  bit   mActive = 0, mDone = 0, mOvf = 0, mTest = 0;
  int   mCh = 0, mPh = 0, mRom = 0, mRes = 0;
  int   mAcc[NUM_CH];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int romEntry(input int k);
    return (16'h0F0F + 16'h1111 * k) & 16'hFFFF;
  endfunction

  function automatic logic [15:0] liveWord(input int i);
    if (i % 50 < 8) return 16'hFFFF;
    if (i % 97 < 5) return 16'h0000;
    return 16'((i * 37) ^ (i << 7));
  endfunction

  // one clock: check outputs, drive inputs, advance model
  task automatic step(input bit v, input logic [15:0] d, input bit st, input bit rd,
                      input bit we = 0, input logic [19:0] wa = '0,
                      input logic [15:0] wd = '0);
    bit pop, push, drop;
    int w, res;
    chk(fifoEmpty == (mCount == 0), "R10", "fifoEmpty", fifoEmpty, mCount == 0);
    chk(fifoFull == (mCount == FDEPTH), "R6", "fifoFull", fifoFull, mCount == FDEPTH);
    chk(cycleActive == mActive, "R4", "cycleActive", cycleActive, mActive);
    chk(cycleDone == mDone, "R4", "cycleDone", cycleDone, mDone);
    chk(overflow == mOvf, "R6", "overflow", overflow, mOvf);
    chk(testMode == mTest, "R8", "testMode", testMode, mTest);
    pop = rd && (mCount > 0);
    if (pop) chk(rdData == expQ[0], mTest ? "R9" : "R3", "rdData", rdData, expQ[0]);

    sampleValid = v; sampleData = d; cycleStart = st; rdEn = rd;
    regWrEn = we; regWrAddr = wa; regWrData = wd;

    push = 0; drop = 0;
    if (st && !mActive) begin
      mActive = 1; mDone = 0; mCh = 0; mPh = 0; mRom = 0; mRes = 0;
      for (int c = 0; c < NUM_CH; c++) mAcc[c] = 0;
    end else if (v && mActive) begin
      w = mTest ? romEntry(mRom) : int'(d);
      mRom = (mRom + 1) % ROMD;
      mAcc[mCh] += w;
      if (mPh == 3) begin
        res = (mAcc[mCh] >> 2) & 16'hFFFF;
        mAcc[mCh] = 0;
        if (mCount == FDEPTH) drop = 1;
        else begin expQ.push_back(res); push = 1; end
        mRes++;
        if (mRes == NUM_CH * RESULTS) begin mActive = 0; mDone = 1; end
      end
      mCh++;
      if (mCh == NUM_CH) begin mCh = 0; mPh = (mPh + 1) % 4; end
    end
    if (pop) void'(expQ.pop_front());
    mCount = mCount + int'(push) - int'(pop);
    if (drop) mOvf = 1;
    else if (we && wa == CTRL) mOvf = 0;
    if (we && wa == CTRL) mTest = (wd == 16'hFF00);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; sampleValid = 0; sampleData = '0; cycleStart = 0;
    regWrEn = 0; regWrAddr = '0; regWrData = '0; rdEn = 0;
    for (int c = 0; c < NUM_CH; c++) mAcc[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(fifoEmpty == 1, "R1", "fifoEmpty", fifoEmpty, 1);
    chk(fifoFull == 0, "R1", "fifoFull", fifoFull, 0);
    chk(cycleActive == 0, "R1", "cycleActive", cycleActive, 0);
    chk(cycleDone == 0, "R1", "cycleDone", cycleDone, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    chk(testMode == 0, "R1", "testMode", testMode, 0);

    // R2: words with no cycle running are ignored
    for (int i = 0; i < 12; i++) step(1, 16'hABCD, 0, 1);
    chk(fifoEmpty == 1, "R2", "idle words fifoEmpty", fifoEmpty, 1);

    // R3, R4: live cycle, full length, continuous draining
    step(0, '0, 1, 1);
    chk(cycleActive == 1, "R2", "started", cycleActive, 1);
    for (int i = 0; i < NUM_CH * RESULTS * 4; i++) step(1, liveWord(i), 0, 1);
    chk(cycleDone == 1, "R4", "done after last result", cycleDone, 1);
    repeat (4) step(0, '0, 0, 1);
    // R4: words after completion ignored
    for (int i = 0; i < 16; i++) step(1, 16'h1234, 0, 1);
    chk(fifoEmpty == 1, "R4", "post-done words fifoEmpty", fifoEmpty, 1);

    // R7/R8: other address ignored, then select test pattern
    step(0, '0, 0, 1, 1, 20'h01030, 16'hFF00);
    chk(testMode == 0, "R7", "foreign address write", testMode, 0);
    step(0, '0, 0, 1, 1, CTRL, 16'hFF00);
    chk(testMode == 1, "R8", "test source selected", testMode, 1);

    // R9, R6, R7, R5: test-pattern cycle with a stalled reader
    step(0, '0, 1, 1);
    for (int i = 0; i < NUM_CH * RESULTS * 4; i++) begin
      bit rd, we;
      if (i == 1001) step(0, '0, 1, 1);           // R5 start while running
      rd = !(i >= 400 && i < 600);
      we = (i == 566) || (i == 568);             // 566 collides with a discard
      step(1, 16'($urandom), 0, rd, we, CTRL, 16'hFF00);
      if (i == 566) chk(overflow == 1, "R7", "set wins over clear", overflow, 1);
      if (i == 568) chk(overflow == 0, "R7", "lone write clears", overflow, 0);
    end
    repeat (20) step(0, '0, 0, 1);
    chk(fifoEmpty == 1, "R10", "drained", fifoEmpty, 1);

    // R8: any other value returns to live data
    step(0, '0, 0, 1, 1, CTRL, 16'h00FF);
    step(0, '0, 0, 1);
    chk(testMode == 0, "R8", "live source reselected", testMode, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule